// File: doc/BRIEF.md
# Programmable Prescaled Tick Timer

This block produces periodic tick interrupts for a real-time clock. It takes a one-cycle enable strobe at the 32.768 kHz reference rate. A free-running 15-bit prescaler divides that strobe by a power of two, chosen by a 4-bit code. A down-counter counts the divided ticks. When the counter has seen the programmed number of ticks, the block raises its interrupt and reloads the counter.

Software uses four word registers. It programs the rate code and the enable in the control register and sets the tick count in the count register. It clears the sticky pending flag by writing a one to it. It can read the live down-counter at any time to see how many divided ticks remain before the next interrupt.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, count, pending and live-count registers all read zero, and `tick_irq` is low.
- R2: The control register holds the rate code in bits [7:4] and the enable in bit 8. While the block is enabled, one divided tick occurs every 2^code reference strobes: code 0 gives one tick per strobe and code 15 gives one tick per 32768 strobes.
- R3: While the block is enabled with a count N ≥ 1, an interrupt fires on every Nth divided tick. The live count reads N just after a reload, drops by one on each divided tick, and is reloaded with the count register value on the tick that fires.
- R4: A firing sets the pending flag, which is bit 0 of the pending register, and drives `tick_irq` high in the same cycle. The flag stays set until software clears it.
- R5: A write with bit 0 set to the pending register clears the flag and lowers `tick_irq`. A write with bit 0 clear leaves the flag unchanged. If a firing and a clearing write fall in the same cycle, the flag ends up set.
- R6: Writing 0 to the enable bit stops the timer, and the live count then holds its value. A write that changes the enable from 0 to 1 loads the live count with the full programmed count.
- R7: A programmed count of zero produces no interrupts.
- R8: A write to the count register while the timer runs does not change the live count. The new value is used from the next reload onward.
- R9: The register addresses are 0 for control, 1 for count, 2 for pending and 3 for the live count. The live count is read-only, so a write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One-cycle strobe at the 32.768 kHz reference rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| tick_irq | output | 1 | Tick interrupt request, follows the pending flag |

## Verification
The timer runs with the reference strobe present on every cycle and also on only every third cycle. It uses rate codes 0, 1, 3 and 15, so that each divider tap and the strobe gating are tried on their own. Counts of 0, 1, 3, 6 and 100 separate the reload-on-fire path, the no-fire zero case and plain decrementing. Count writes in mid-run, enable toggles, and writes to the pending and live-count registers with zero and nonzero data separate the deferred-reload, hold, restart and write-one-clear behaviours.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tick_irq
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_PEND = 2'd2;
  localparam logic [1:0] A_LIVE = 2'd3;

  logic [PRE_W-1:0] pre_q;
  logic [3:0]       sel_q;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_q;
  logic             pend_q;

  logic [PRE_W-1:0] tap_mask;
  logic             strobe;
  logic             wr_ctrl, wr_cnt, wr_pend;
  logic             start;
  logic             fire;

  assign wr_ctrl  = wr_en && addr == A_CTRL;
  assign wr_cnt   = wr_en && addr == A_CNT;
  assign wr_pend  = wr_en && addr == A_PEND;
  assign start    = wr_ctrl && wdata[8] && !run_q;

  assign tap_mask = PRE_W'((32'd1 << sel_q) - 32'd1);
  assign strobe   = ref_en && &(pre_q | ~tap_mask);
  assign fire     = run_q && strobe && !start && cur_q == CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)      pre_q <= '0;
    else if (ref_en) pre_q <= pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sel_q <= '0;
    end else if (wr_ctrl) begin
      run_q <= wdata[8];
      sel_q <= wdata[7:4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cur_q <= '0;
    else if (start)
      cur_q <= cnt_q;
    else if (run_q && strobe) begin
      if (cur_q <= CNT_W'(1)) cur_q <= cnt_q;
      else                    cur_q <= cur_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      pend_q <= 1'b0;
    else if (fire)                   pend_q <= 1'b1;
    else if (wr_pend && wdata[0])    pend_q <= 1'b0;
  end

  assign tick_irq = pend_q;

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: rdata = DATA_W'({run_q, sel_q, 4'b0000});
      A_CNT:  rdata = DATA_W'(cnt_q);
      A_PEND: rdata = DATA_W'(pend_q);
      A_LIVE: rdata = DATA_W'(cur_q);
      default: rdata = '0;
    endcase
  end

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !(wr_pend && wdata[0]) |=> pend_q); // R4

  AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend && wdata[0] && !(run_q && strobe) |=> !pend_q); // R5

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !wr_ctrl |=> $stable(cur_q)); // R6

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cur_q == $past(cnt_q)); // R6

  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == '0 && cur_q == '0 && !pend_q |=> !pend_q); // R7

  AST_FIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> cur_q == $past(cnt_q)); // R3

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && strobe && !wr_ctrl && cur_q > CNT_W'(1) |=> cur_q == $past(cur_q) - CNT_W'(1)); // R8
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ref_en = 0;
  logic        wr_en = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        tick_irq;

  int checks = 0, errors = 0;
  int ref_gap = 0;
  int gap_cnt = 0;
  int m_pre = 0, m_ctrl = 0, m_cnt = 0, m_cur = 0, m_pend = 0;

  tick_timer uut (.clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata), .tick_irq(tick_irq));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (gap_cnt >= ref_gap) begin ref_en <= 1; gap_cnt <= 0; end
    else begin ref_en <= 0; gap_cnt <= gap_cnt + 1; end
  end

  always @(posedge clk) begin
    int sel, en, strb, fire, ncur, npend;
    if (!rst_n) begin
      m_pre = 0; m_ctrl = 0; m_cnt = 0; m_cur = 0; m_pend = 0;
    end else begin
      sel  = (m_ctrl >> 4) & 15;
      en   = (m_ctrl >> 8) & 1;
      strb = (ref_en && ((m_pre % (1 << sel)) == (1 << sel) - 1)) ? 1 : 0;
      fire = 0;
      ncur = m_cur;
      if (wr_en && addr == 0 && wdata[8] && en == 0) ncur = m_cnt;
      else if (en == 1 && strb == 1) begin
        if (m_cur == 1) begin fire = 1; ncur = m_cnt; end
        else if (m_cur == 0) ncur = m_cnt;
        else ncur = m_cur - 1;
      end
      npend = m_pend;
      if (wr_en && addr == 2 && wdata[0]) npend = 0;
      if (fire == 1) npend = 1;
      if (wr_en && addr == 0) m_ctrl = int'(wdata & 32'h1F0);
      if (wr_en && addr == 1) m_cnt = int'(wdata & 32'hFFFF);
      if (ref_en) m_pre = (m_pre + 1) % 32768;
      m_cur = ncur;
      m_pend = npend;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (tick_irq !== m_pend[0]) begin
        errors++;
        $display("FAIL R4 tick_irq vs model at %0t: got %0b expected %0b", $time, tick_irq, m_pend[0]);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d: got %0d expected %0d", req, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    checks++;
    if (tick_irq !== exp) begin
      errors++;
      $display("FAIL %s tick_irq: got %0b expected %0b", req, tick_irq, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] held;
    run(4); rst_n = 1; run(1);
    rd(0, 0, "R1"); rd(1, 0, "R1"); rd(2, 0, "R1"); rd(3, 0, "R1"); chk_irq(0, "R1");

    wr(1, 100); wr(0, 32'h130);
    run(80);
    rd(3, 90, "R2");
    rd(0, 32'h130, "R9"); rd(1, 100, "R9");

    wr(0, 32'h030);
    addr = 3; #1; held = rdata;
    run(20); rd(3, held, "R6");
    wr(3, 5); rd(3, held, "R9");

    wr(1, 3); wr(0, 32'h100);
    rd(3, 3, "R6");
    run(20); chk_irq(1, "R3"); rd(2, 1, "R4");

    wr(0, 0);
    wr(2, 0); rd(2, 1, "R5"); chk_irq(1, "R5");
    wr(2, 1); rd(2, 0, "R5"); chk_irq(0, "R5");

    wr(1, 6); wr(0, 32'h100);
    run(1);
    wr(1, 2);
    run(3); rd(3, 2, "R8"); rd(2, 1, "R8");

    wr(0, 0); wr(2, 1); wr(1, 0);
    ref_gap = 1;
    wr(0, 32'h100);
    run(200); chk_irq(0, "R7"); rd(3, 0, "R7");

    wr(0, 0); wr(2, 1); wr(1, 3);
    ref_gap = 2;
    wr(0, 32'h110);
    run(150); rd(1, 3, "R3");

    wr(0, 0); wr(2, 1); wr(1, 1);
    ref_gap = 0;
    wr(0, 32'h1F0);
    run(33000); chk_irq(1, "R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule